// File: doc/BRIEF.md
# Acquisition Cycle Sequencer

This block paces the acquisition cycles of a multi-branch calorimeter readout. It turns trigger edges or an internal period timer into clock-aligned start and stop strobes, copies them to every readout branch, and drives an acquisition-active level plus a matching power-enable level so that the front-ends can be powered only while they take data.

Two run modes are selected by `mode_sel`. In fixed-rate mode (`mode_sel`=0) every accepted initiation produces one cycle of fixed length and the busy lines are ignored; the cycle rate comes from the external trigger or from the programmable period timer, and the spill level can optionally veto starts. In busy-controlled mode (`mode_sel`=1) a trigger opens a run; the cycle stops as soon as any unmasked branch reports busy, and restarts once every branch is released and spill is present. A busy line may be a steady level or a toggling signal; both are recognised through a programmable quiet window.

Trigger, spill and busy inputs are asynchronous and pass through two-flop synchronizers inside the block.

Top module: `acq_cycle_seq`

## Requirements
- R1: With `mode_sel`=0 the busy inputs have no effect: a cycle lasts its programmed length even while a branch is busy.
- R2: A rising edge on `trig_in` accepted while idle gives a one-cycle start strobe in the cycle after clock edge number `start_dly`+4, counting the first edge that samples the trigger high as edge 1.
- R3: In fixed-rate mode `acq_active` stays high for exactly `stop_dly`+1 cycles, and the one-cycle stop strobe is high in the first cycle where `acq_active` is low again.
- R4: In fixed-rate mode with `period_cfg` nonzero, an initiation is generated every `period_cfg` cycles; initiations that arrive while a cycle is pending or active are dropped, so consecutive starts are spaced by the smallest multiple of `period_cfg` that is at least `start_dly`+`stop_dly`+3.
- R5: In fixed-rate mode with `spill_gate`=1, an initiation arriving while the synchronized spill is low is discarded.
- R6: In busy-controlled mode the cycle has no fixed length; a branch raising a steady busy level produces the stop strobe, with `acq_active` low, in the cycle after the third edge that samples it high.
- R7: In busy-controlled mode a restart needs all unmasked branches released and spill high: after the last busy fall the start strobe follows edge `busy_win`+4; if spill is low, the restart waits and follows edge 3 after spill rises. An initial trigger is also discarded while spill is low.
- R8: A busy line that pulses with quiet gaps shorter than `busy_win` cycles counts as busy the whole time, so no restart happens while it pulses.
- R9: A branch whose `busy_mask` bit is 1 is ignored in the busy combination (bit i belongs to `busy_in[i]`).
- R10: All `NCH` bits of `start_o` and of `stop_o` carry the same strobe, and `pwr_en` equals `acq_active`.
- R11: A trigger held high starts exactly one cycle; only its rising edge counts.
- R12: During reset all outputs are low.
- R13: Clearing `mode_sel` during a busy-controlled run returns the block to idle; no restart follows when busy clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bunch-crossing clock |
| rst_n | input | 1 | Active-low reset |
| trig_in | input | 1 | Asynchronous external start trigger |
| spill_in | input | 1 | Asynchronous beam-spill level |
| busy_in | input | NCH | Asynchronous busy line per branch, steady or toggling |
| busy_mask | input | NCH | 1 ignores the matching busy line |
| mode_sel | input | 1 | 0 fixed-rate, 1 busy-controlled |
| spill_gate | input | 1 | 1 makes spill veto starts in fixed-rate mode |
| start_dly | input | DW | Cycles added between trigger acceptance and start |
| stop_dly | input | DW | Fixed-rate cycle length minus one |
| period_cfg | input | DW | Internal initiation period, 0 disables |
| busy_win | input | WW | Quiet cycles needed to release a busy line (1 or more) |
| start_o | output | NCH | Start strobe per branch |
| stop_o | output | NCH | Stop strobe per branch |
| acq_active | output | 1 | Acquisition in progress |
| pwr_en | output | 1 | Front-end power enable |

## Verification
The bench sweeps both delays over a small grid and checks each start and stop edge to the cycle, so an off-by-one in the delay counter or the synchronizer depth shows up as a shifted strobe. It releases busy lines after steady and pulsed busy and measures the restart latency against the quiet window; a detector that watched only the level would restart during a narrow pulse train, and one that ignored spill would restart without beam. A period shorter than a cycle checks that overlapping initiations are dropped rather than queued, a held trigger checks edge detection, and a masked busy line and a mode change mid-run check that neither stops nor restarts leak through.

// File: rtl/acq_cycle_seq.sv
module acq_cycle_seq #(
  parameter int NCH = 3,
  parameter int DW  = 16,
  parameter int WW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig_in,
  input  logic           spill_in,
  input  logic [NCH-1:0] busy_in,
  input  logic [NCH-1:0] busy_mask,
  input  logic           mode_sel,
  input  logic           spill_gate,
  input  logic [DW-1:0]  start_dly,
  input  logic [DW-1:0]  stop_dly,
  input  logic [DW-1:0]  period_cfg,
  input  logic [WW-1:0]  busy_win,
  output logic [NCH-1:0] start_o,
  output logic [NCH-1:0] stop_o,
  output logic           acq_active,
  output logic           pwr_en
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACQ, S_HOLD} state_t;

  state_t st;
  logic [DW-1:0] cnt;
  logic [DW-1:0] tmr;
  logic          run_busy;
  logic          start_q, stop_q, acq_q;

  // input synchronizers
  logic [2:0] trig_sr;
  logic [1:0] spill_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_sr  <= '0;
      spill_sr <= '0;
    end else begin
      trig_sr  <= {trig_sr[1:0], trig_in};
      spill_sr <= {spill_sr[0], spill_in};
    end
  end

  wire trig_rise = trig_sr[1] & ~trig_sr[2];
  wire spill_ok  = spill_sr[1];

  // per-branch busy detection: level or recent toggle
  logic [NCH-1:0] busy_ch;

  for (genvar g = 0; g < NCH; g++) begin : g_busy
    logic [2:0]    sr;
    logic [WW-1:0] quiet;
    wire lvl = sr[1];
    wire tog = sr[1] ^ sr[2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sr    <= '0;
        quiet <= '1;
      end else begin
        sr <= {sr[1:0], busy_in[g]};
        if (lvl | tog)
          quiet <= '0;
        else if (quiet != '1)
          quiet <= quiet + 1'b1;
      end
    end

    assign busy_ch[g] = lvl | (quiet < busy_win);
  end

  wire busy_any = |(busy_ch & ~busy_mask);

  // internal period generator for fixed-rate mode
  wire tmr_run = !mode_sel && (period_cfg != '0);
  wire tick    = tmr_run && (tmr >= period_cfg - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tmr <= '0;
    else if (!tmr_run || tick)
      tmr <= '0;
    else
      tmr <= tmr + 1'b1;
  end

  wire go      = trig_rise | tick;
  wire go_gate = mode_sel ? spill_ok : (!spill_gate || spill_ok);

  // cycle sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      run_busy <= 1'b0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      acq_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go && go_gate) begin
            st       <= S_WAIT;
            cnt      <= start_dly;
            run_busy <= mode_sel;
          end
        end
        S_WAIT: begin
          if (cnt == '0) begin
            st      <= S_ACQ;
            start_q <= 1'b1;
            acq_q   <= 1'b1;
            cnt     <= stop_dly;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ACQ: begin
          if (run_busy) begin
            if (!mode_sel) begin
              st     <= S_IDLE;
              stop_q <= 1'b1;
              acq_q  <= 1'b0;
            end else if (busy_any) begin
              st     <= S_HOLD;
              stop_q <= 1'b1;
              acq_q  <= 1'b0;
            end
          end else if (cnt == '0) begin
            st     <= S_IDLE;
            stop_q <= 1'b1;
            acq_q  <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          if (!mode_sel) begin
            st <= S_IDLE;
          end else if (!busy_any && spill_ok) begin
            st      <= S_ACQ;
            start_q <= 1'b1;
            acq_q   <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign start_o    = {NCH{start_q}};
  assign stop_o     = {NCH{stop_q}};
  assign acq_active = acq_q;
  assign pwr_en     = acq_q;

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  assert_stop_ends_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (!acq_q && $past(acq_q)));

  assert_start_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_q) |-> start_q);

  assert_fixed_ignores_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(acq_q) && !run_busy) |-> $past(cnt == '0));

  assert_busy_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(acq_q) && run_busy && $past(mode_sel)) |-> $past(busy_any));

  assert_restart_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acq_q) && $past(st == S_HOLD)) |-> $past(spill_ok && !busy_any));

endmodule

// File: tb/acq_cycle_seq_test.sv
`timescale 1ns/1ps
module acq_cycle_seq_test;
  localparam int NCH = 3;
  localparam int DW  = 16;
  localparam int WW  = 8;
  localparam int W   = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic trig_in = 0, spill_in = 1, mode_sel = 0, spill_gate = 0;
  logic [NCH-1:0] busy_in = '0, busy_mask = '0;
  logic [DW-1:0] start_dly = '0, stop_dly = '0, period_cfg = '0;
  logic [WW-1:0] busy_win = WW'(W);
  logic [NCH-1:0] start_o, stop_o;
  logic acq_active, pwr_en;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  acq_cycle_seq #(.NCH(NCH), .DW(DW), .WW(WW)) uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .spill_in(spill_in),
    .busy_in(busy_in), .busy_mask(busy_mask), .mode_sel(mode_sel),
    .spill_gate(spill_gate), .start_dly(start_dly), .stop_dly(stop_dly),
    .period_cfg(period_cfg), .busy_win(busy_win), .start_o(start_o),
    .stop_o(stop_o), .acq_active(acq_active), .pwr_en(pwr_en));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_start(input int lim, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!start_o[0] && k < lim);
  endtask

  task automatic wait_stop(input int lim, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!stop_o[0] && k < lim);
  endtask

  task automatic count_starts(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (start_o[0]) c++;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k, n, c;
    repeat (5) @(negedge clk);
    chk("R12 start_o in reset", int'(start_o), 0);
    chk("R12 stop_o in reset", int'(stop_o), 0);
    chk("R12 acq_active in reset", int'(acq_active), 0);
    chk("R12 pwr_en in reset", int'(pwr_en), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // fixed-rate delay sweep
    for (int d = 0; d < 4; d++) begin
      for (int l = 0; l < 4; l++) begin
        start_dly = DW'(d);
        stop_dly  = DW'(l);
        trig_in   = 1;
        wait_start(60, k);
        trig_in = 0;
        chk($sformatf("R2 start latency d=%0d", d), k, d + 4);
        chk("R10 start on all branches", int'(start_o), 7);
        chk("R10 pwr_en follows acq", int'(pwr_en), 1);
        n = 1;
        forever begin
          @(negedge clk);
          if (acq_active) n++;
          else break;
        end
        chk($sformatf("R3 active length l=%0d", l), n, l + 1);
        chk("R3 stop strobe on all branches", int'(stop_o), 7);
        chk("R10 pwr_en low after stop", int'(pwr_en), 0);
        @(negedge clk);
        chk("R3 stop strobe single cycle", int'(stop_o), 0);
        repeat (3) @(negedge clk);
      end
    end

    // held trigger
    start_dly = 0; stop_dly = 2;
    trig_in = 1;
    count_starts(40, c);
    trig_in = 0;
    chk("R11 held trigger gives one start", c, 1);
    repeat (5) @(negedge clk);

    // busy ignored in fixed-rate mode
    busy_in = 3'b001;
    start_dly = 1; stop_dly = 4;
    trig_in = 1;
    wait_start(60, k);
    trig_in = 0;
    chk("R1 start despite busy", k, 5);
    n = 1;
    forever begin
      @(negedge clk);
      if (acq_active) n++;
      else break;
    end
    chk("R1 length unaffected by busy", n, 5);
    busy_in = 0;
    repeat (W + 6) @(negedge clk);

    // spill veto in fixed-rate mode
    spill_gate = 1; spill_in = 0;
    trig_in = 1;
    count_starts(20, c);
    trig_in = 0;
    chk("R5 start vetoed without spill", c, 0);
    spill_in = 1;
    repeat (4) @(negedge clk);
    trig_in = 1;
    wait_start(60, k);
    trig_in = 0;
    chk("R5 start with spill present", k, 5);
    spill_gate = 0;
    repeat (10) @(negedge clk);

    // internal period
    start_dly = 2; stop_dly = 3;
    period_cfg = 12;
    wait_start(60, k);
    wait_start(60, k);
    chk("R4 start spacing period 12", k, 12);
    period_cfg = 4;
    wait_start(60, k);
    wait_start(60, k);
    chk("R4 spacing when period 4 overlaps", k, 8);
    wait_start(60, k);
    chk("R4 spacing repeats", k, 8);
    period_cfg = 0;
    repeat (20) @(negedge clk);
    chk("R4 idle with period 0", int'(acq_active), 0);

    // busy-controlled mode
    mode_sel = 1; spill_in = 0; start_dly = 1; stop_dly = 2;
    trig_in = 1;
    count_starts(15, c);
    trig_in = 0;
    chk("R7 initial trigger needs spill", c, 0);
    spill_in = 1;
    repeat (4) @(negedge clk);
    trig_in = 1;
    wait_start(60, k);
    trig_in = 0;
    chk("R2 start latency in busy mode", k, 5);
    repeat (8) @(negedge clk);
    chk("R6 no fixed length in busy mode", int'(acq_active), 1);
    busy_in[0] = 1;
    wait_stop(60, k);
    chk("R6 stop latency after busy", k, 3);
    chk("R6 acq low at stop", int'(acq_active), 0);
    repeat (10) @(negedge clk);
    chk("R6 held while busy", int'(acq_active), 0);
    busy_in[0] = 0;
    wait_start(60, k);
    chk("R7 restart after quiet window", k, W + 4);

    // spill holds restart
    busy_in[0] = 1;
    wait_stop(60, k);
    chk("R6 second stop latency", k, 3);
    spill_in = 0;
    busy_in[0] = 0;
    count_starts(W + 10, c);
    chk("R7 no restart without spill", c, 0);
    spill_in = 1;
    wait_start(60, k);
    chk("R7 restart after spill rises", k, 3);

    // pulsing busy
    n = 0; c = 0;
    for (int i = 0; i < 32; i++) begin
      busy_in[1] = (i % 4 == 0);
      @(negedge clk);
      if (stop_o[0]) n++;
      if (start_o[0]) c++;
    end
    chk("R8 one stop from pulse train", n, 1);
    chk("R8 no restart while pulsing", c, 0);
    busy_in[1] = 1;
    @(negedge clk);
    busy_in[1] = 0;
    wait_start(60, k);
    chk("R8 restart after last pulse", k, W + 4);

    // masked branch
    busy_mask = 3'b100;
    busy_in[2] = 1;
    n = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (stop_o[0]) n++;
    end
    chk("R9 masked busy gives no stop", n, 0);
    chk("R9 acq stays active", int'(acq_active), 1);
    busy_in[2] = 0;
    repeat (W + 6) @(negedge clk);
    busy_mask = 0;
    repeat (3) @(negedge clk);
    chk("R9 still active after unmask", int'(acq_active), 1);

    // leaving busy mode mid-run
    busy_in[0] = 1;
    wait_stop(60, k);
    chk("R13 stop before mode change", k, 3);
    mode_sel = 0;
    repeat (2) @(negedge clk);
    busy_in[0] = 0;
    count_starts(W + 10, c);
    chk("R13 no restart after mode change", c, 0);
    chk("R13 idle after mode change", int'(acq_active), 0);
    start_dly = 0; stop_dly = 1;
    trig_in = 1;
    wait_start(60, k);
    trig_in = 0;
    chk("R13 fixed mode works again", k, 4);
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule